// File: doc/BRIEF.md
# Infrared Remote Carrier Generator

This block produces the modulated carrier for an infrared remote-control transmitter. A fast clock is divided into a carrier whose period and high time come from a small table of four settings. The carrier is divided again into a slower reference period, tau. Tau times the bursts of carrier that are sent, and it also drives a programmable tau counter that raises an interrupt flag.

Software controls the block through a plain single-cycle register port. A write takes effect at the clock edge where `wr_en` is high. Read data is combinational from `addr`. A read has a side effect only when `rd_en` is high, so the port has no back-pressure and no wait states. Two ways of transmitting are supported. In the hardware-timed way, software writes a burst length of 0 to 3 tau periods for each symbol, and the burst starts on the next tau boundary. In the software way, a force bit places the raw carrier on the pin for as long as software holds it. Encoding data bits into pulse positions is left to software.

Register map (address: fields):
- 0 control: bit 0 is run enable, bit 1 is force, bit 2 is interrupt enable.
- 1 shape: bits 1:0 select the carrier, bits 3:2 select tau.
- 2 burst length: bits 1:0.
- 3 tau count: bits TICK_W-1:0.
- 4 status: bit 0 is the interrupt flag, bit 1 shows that the block is running.

All other addresses read as zero.

Top module: `irc_carrier_top`

## Requirements
- R1: The carrier setting (shape bits 1:0) selects the carrier period and high time in clock cycles. Code 0 gives period 8 with 2 cycles high, code 1 gives period 8 with 3 high, code 2 gives period 12 with 4 high, and code 3 gives period 12 with 3 high. The high part comes first in each period.
- R2: The tau select (shape bits 3:2) sets one tau period to 12, 16, 20 or 32 carrier periods for codes 0 to 3. A tau boundary falls every (carrier period × tau length) clocks, counted from the enabling write.
- R3: A write to the burst-length register arms one burst. At the next tau boundary the output carries the carrier for that many tau periods (0 to 3), and then stays low until the register is written again.
- R4: The burst-length register reads 0 after reset and after any control write with bit 0 clear. While no burst is active and force is clear, the output stays low.
- R5: A write of a nonzero value V to the tau-count register starts a count of tau boundaries. When the V-th boundary after the write arrives, the interrupt flag (status bit 0) sets, whatever the interrupt enable is. A new write restarts the count, the written value stays readable, and a value of 0 never sets the flag.
- R6: A status read with `rd_en` high clears the flag, unless the flag is set in the same cycle. `irq` is high exactly when the flag and interrupt enable (control bit 2) are both 1. The enable is 0 after reset.
- R7: Clearing run enable stops the block only at the next tau boundary. Until then status bit 1 stays 1. A control write with bit 0 set starts the block on the next clock with its dividers at phase zero.
- R8: With force set while running, the output carries the carrier regardless of the burst state.
- R9: While the block is not running, `ir_out` is low one clock later and stays low.
- R10: After reset, every register reads 0 and `ir_out` and `irq` are low. `ir_out` is registered and lags the internal carrier by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast source clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe (only needed for clear-on-read) |
| addr | input | 3 | register address |
| wdata | input | DW | write data |
| rdata | output | DW | read data, combinational from addr |
| ir_out | output | 1 | carrier output pin |
| irq | output | 1 | interrupt request |

## Verification
A wrong carrier counter phase shows on `ir_out` within one carrier period (at most 12 clocks) as a high time or edge in the wrong place. A wrong tau phase or burst counter shows at the next tau boundary, at most 384 clocks later, as a burst that starts or ends late. A tau counter that restarts wrongly, or a stop that does not wait, shows in status bits 0 and 1 and on `irq` within one tau period. Because the register view and both outputs are compared against a behavioural model every clock, any such divergence is reported in the first cycle where it becomes visible.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int ADDR_W = 3;
  localparam int CDIV_W = 4;   // holds carrier counts up to 11
  localparam int TDIV_W = 5;   // holds tau counts up to 31
  localparam int WID_W  = 2;   // burst length field

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 3'd0,
    RA_SHAPE = 3'd1,
    RA_WIDTH = 3'd2,
    RA_TICKS = 3'd3,
    RA_STAT  = 3'd4
  } reg_sel_e;

  // control field positions
  localparam int CTL_RUN   = 0;
  localparam int CTL_FORCE = 1;
  localparam int CTL_IEN   = 2;
  // status field positions
  localparam int ST_FLAG   = 0;
  localparam int ST_RUN    = 1;

  // last count of one carrier period
  function automatic logic [CDIV_W-1:0] car_last(input logic [1:0] sel);
    return sel[1] ? 4'd11 : 4'd7;
  endfunction

  // number of high clocks at the start of a carrier period
  function automatic logic [CDIV_W-1:0] car_high(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd2;
      2'd1:    return 4'd3;
      2'd2:    return 4'd4;
      default: return 4'd3;
    endcase
  endfunction

  // last carrier index of one tau period
  function automatic logic [TDIV_W-1:0] tau_last(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd11;
      2'd1:    return 5'd15;
      2'd2:    return 5'd19;
      default: return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/irc_regs.sv
module irc_regs
  import irc_pkg::*;
#(
  parameter int DW     = 8,
  parameter int TICK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              run,
  input  logic              flag,
  output logic [DW-1:0]     rdata,
  output logic              en_q,
  output logic              force_q,
  output logic              ien_q,
  output logic [1:0]        cmode_q,
  output logic [1:0]        tsel_q,
  output logic [WID_W-1:0]  width_q,
  output logic [TICK_W-1:0] ticks_q,
  output logic              on_wr,
  output logic              off_wr,
  output logic              width_wr,
  output logic              ticks_wr,
  output logic              stat_rd
);
  reg_sel_e sel;
  logic     unused_wbits;

  assign sel          = reg_sel_e'(addr);
  assign unused_wbits = ^wdata;

  assign on_wr    = wr_en && (sel == RA_CTRL) &&  wdata[CTL_RUN];
  assign off_wr   = wr_en && (sel == RA_CTRL) && !wdata[CTL_RUN];
  assign width_wr = wr_en && (sel == RA_WIDTH);
  assign ticks_wr = wr_en && (sel == RA_TICKS);
  assign stat_rd  = rd_en && (sel == RA_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      force_q <= 1'b0;
      ien_q   <= 1'b0;
      cmode_q <= '0;
      tsel_q  <= '0;
      width_q <= '0;
      ticks_q <= '0;
    end else if (wr_en) begin
      case (sel)
        RA_CTRL: begin
          en_q    <= wdata[CTL_RUN];
          force_q <= wdata[CTL_FORCE];
          ien_q   <= wdata[CTL_IEN];
          // switching the carrier off discards any burst length
          if (!wdata[CTL_RUN]) width_q <= '0;
        end
        RA_SHAPE: begin
          cmode_q <= wdata[1:0];
          tsel_q  <= wdata[3:2];
        end
        RA_WIDTH: width_q <= wdata[WID_W-1:0];
        RA_TICKS: ticks_q <= wdata[TICK_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      RA_CTRL: begin
        rdata[CTL_RUN]   = en_q;
        rdata[CTL_FORCE] = force_q;
        rdata[CTL_IEN]   = ien_q;
      end
      RA_SHAPE: begin
        rdata[1:0] = cmode_q;
        rdata[3:2] = tsel_q;
      end
      RA_WIDTH: rdata[WID_W-1:0]  = width_q;
      RA_TICKS: rdata[TICK_W-1:0] = ticks_q;
      RA_STAT: begin
        rdata[ST_FLAG] = flag;
        rdata[ST_RUN]  = run;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irc_carrier_div.sv
module irc_carrier_div
  import irc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] cmode,
  output logic       carrier,
  output logic       c_wrap
);
  logic [CDIV_W-1:0] cnt_q;
  logic [CDIV_W-1:0] last;
  logic [CDIV_W-1:0] high;

  assign last = car_last(cmode);
  assign high = car_high(cmode);

  // >= keeps the wrap safe when the shape shrinks mid-period
  assign c_wrap  = run && (cnt_q >= last);
  assign carrier = run && (cnt_q < high);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || c_wrap)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/irc_tau_div.sv
module irc_tau_div
  import irc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       c_wrap,
  input  logic [1:0] tsel,
  output logic       tau_rise
);
  logic [TDIV_W-1:0] cnt_q;
  logic [TDIV_W-1:0] last;

  assign last     = tau_last(tsel);
  assign tau_rise = c_wrap && (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (c_wrap)   cnt_q <= tau_rise ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/irc_burst_gate.sv
module irc_burst_gate
  import irc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tau_rise,
  input  logic             width_wr,
  input  logic             off_wr,
  input  logic [WID_W-1:0] width_q,
  output logic             gate
);
  logic             pend_q;
  logic [WID_W-1:0] left_q;

  assign gate = |left_q;

  // a written length waits for the next tau boundary
  always_ff @(posedge clk) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (off_wr)   pend_q <= 1'b0;
    else if (width_wr) pend_q <= 1'b1;
    else if (tau_rise) pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        left_q <= '0;
    else if (!run)     left_q <= '0;
    else if (tau_rise) begin
      if (pend_q)      left_q <= width_q;
      else if (gate)   left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/irc_tick_irq.sv
module irc_tick_irq #(
  parameter int TICK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tau_rise,
  input  logic              ticks_wr,
  input  logic [TICK_W-1:0] ticks_new,
  input  logic [TICK_W-1:0] ticks_q,
  input  logic              stat_rd,
  output logic              flag,
  output logic              set_evt
);
  localparam logic [TICK_W-1:0] ONE = TICK_W'(1);

  logic [TICK_W-1:0] cnt_q;
  logic [TICK_W-1:0] cnt_nxt;
  logic              armed_q;

  assign cnt_nxt = cnt_q + ONE;
  assign set_evt = !ticks_wr && tau_rise && armed_q && (cnt_nxt == ticks_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (ticks_wr) begin
      cnt_q   <= '0;
      armed_q <= |ticks_new;
    end else if (tau_rise && armed_q) begin
      if (set_evt) armed_q <= 1'b0;
      else         cnt_q   <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (stat_rd) flag <= 1'b0;
  end
endmodule

// File: rtl/irc_carrier_top.sv
module irc_carrier_top
  import irc_pkg::*;
#(
  parameter int DW      = 8,
  parameter int TICK_W  = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              ir_out,
  output logic              irq
);
  logic              en_q, force_q, ien_q;
  logic [1:0]        cmode_q, tsel_q;
  logic [WID_W-1:0]  width_q;
  logic [TICK_W-1:0] ticks_q;
  logic              on_wr, off_wr, width_wr, ticks_wr, stat_rd;
  logic              run_q;
  logic              carrier, c_wrap, tau_rise, gate;
  logic              flag, set_evt;
  logic              drive;

  irc_regs #(.DW(DW), .TICK_W(TICK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .run(run_q), .flag(flag), .rdata(rdata),
    .en_q(en_q), .force_q(force_q), .ien_q(ien_q), .cmode_q(cmode_q),
    .tsel_q(tsel_q), .width_q(width_q), .ticks_q(ticks_q),
    .on_wr(on_wr), .off_wr(off_wr), .width_wr(width_wr),
    .ticks_wr(ticks_wr), .stat_rd(stat_rd)
  );

  // run starts at once, but stops only on a tau boundary
  always_ff @(posedge clk) begin
    if (!rst_n)                   run_q <= 1'b0;
    else if (on_wr)               run_q <= 1'b1;
    else if (!en_q && tau_rise)   run_q <= 1'b0;
  end

  irc_carrier_div u_cdiv (
    .clk(clk), .rst_n(rst_n), .run(run_q), .cmode(cmode_q),
    .carrier(carrier), .c_wrap(c_wrap)
  );

  irc_tau_div u_tdiv (
    .clk(clk), .rst_n(rst_n), .run(run_q), .c_wrap(c_wrap),
    .tsel(tsel_q), .tau_rise(tau_rise)
  );

  irc_burst_gate u_gate (
    .clk(clk), .rst_n(rst_n), .run(run_q), .tau_rise(tau_rise),
    .width_wr(width_wr), .off_wr(off_wr), .width_q(width_q), .gate(gate)
  );

  irc_tick_irq #(.TICK_W(TICK_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .tau_rise(tau_rise), .ticks_wr(ticks_wr),
    .ticks_new(wdata[TICK_W-1:0]), .ticks_q(ticks_q), .stat_rd(stat_rd),
    .flag(flag), .set_evt(set_evt)
  );

  assign drive = carrier && (force_q || gate);
  assign irq   = flag && ien_q;

  generate
    if (OUT_REG) begin : g_out_ff
      logic ir_q;
      always_ff @(posedge clk) begin
        if (!rst_n) ir_q <= 1'b0;
        else        ir_q <= drive;
      end
      assign ir_out = ir_q;
    end else begin : g_out_comb
      assign ir_out = drive;
    end
  endgenerate
endmodule

// File: rtl/irc_carrier_chk.sv
module irc_carrier_chk
  import irc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wdata0,
  input logic              ir_out,
  input logic              run,
  input logic              tau_rise,
  input logic [WID_W-1:0]  width,
  input logic              gate,
  input logic              flag,
  input logic              set_evt,
  input logic              force_on,
  input logic              carrier
);
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !ir_out); // R9

  AST_STOP_ON_TAU: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $past(tau_rise)); // R7

  AST_WIDTH_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_CTRL && !wdata0) |=> (width == '0)); // R4

  AST_BURST_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> $past(tau_rise)); // R3

  AST_FLAG_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == RA_STAT && !set_evt) |=> !flag); // R6

  AST_FORCE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && force_on && carrier) |=> ir_out); // R8
endmodule

bind irc_carrier_top irc_carrier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata0(wdata[0]), .ir_out(ir_out), .run(run_q), .tau_rise(tau_rise),
  .width(width_q), .gate(gate), .flag(flag), .set_evt(set_evt),
  .force_on(force_q), .carrier(carrier)
);

// File: tb/sim_irc_carrier_top.sv
module sim_irc_carrier_top;
  localparam int CLK_P = 10;
  localparam int Q     = CLK_P / 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ir_out, irq;

  int vectors = 0;
  int misses  = 0;
  int hi_total = 0;
  bit go = 1'b0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irc_carrier_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ir_out(ir_out), .irq(irq)
  );

  // behavioural reference state
  int m_en, m_frc, m_ien, m_cm, m_ts, m_wd, m_tk;
  int m_run, m_dc, m_tc, m_pend, m_left, m_cnt, m_arm, m_flag, m_ir;

  always @(posedge clk) begin
    int n, h, tl, a, d;
    bit cw, tr, car, setv;
    if (!rst_n) begin
      m_en = 0; m_frc = 0; m_ien = 0; m_cm = 0; m_ts = 0; m_wd = 0; m_tk = 0;
      m_run = 0; m_dc = 0; m_tc = 0; m_pend = 0; m_left = 0; m_cnt = 0;
      m_arm = 0; m_flag = 0; m_ir = 0;
    end else begin
      a = int'(addr); d = int'(wdata);
      n  = (m_cm >= 2) ? 12 : 8;
      h  = (m_cm == 0) ? 2 : (m_cm == 2) ? 4 : 3;
      tl = (m_ts == 0) ? 12 : (m_ts == 1) ? 16 : (m_ts == 2) ? 20 : 32;
      cw  = (m_run != 0) && (m_dc >= n - 1);
      tr  = cw && (m_tc >= tl - 1);
      car = (m_run != 0) && (m_dc < h);
      m_ir = (car && (m_frc != 0 || m_left != 0)) ? 1 : 0;
      if (m_run == 0) begin m_dc = 0; m_tc = 0; end
      else if (cw) begin m_dc = 0; m_tc = tr ? 0 : m_tc + 1; end
      else m_dc = m_dc + 1;
      if (m_run == 0) m_left = 0;
      else if (tr) m_left = (m_pend != 0) ? m_wd : (m_left > 0 ? m_left - 1 : 0);
      if (wr_en && a == 0 && d[0] == 0) m_pend = 0;
      else if (wr_en && a == 2) m_pend = 1;
      else if (tr) m_pend = 0;
      setv = 0;
      if (wr_en && a == 3) begin m_cnt = 0; m_arm = ((d & 15) != 0); end
      else if (tr && m_arm != 0) begin
        if (m_cnt + 1 == m_tk) begin setv = 1; m_arm = 0; end
        else m_cnt = m_cnt + 1;
      end
      if (setv) m_flag = 1;
      else if (rd_en && a == 4) m_flag = 0;
      if (wr_en && a == 0 && d[0] == 1) m_run = 1;
      else if (m_en == 0 && tr) m_run = 0;
      if (wr_en) begin
        case (a)
          0: begin m_en = d & 1; m_frc = (d >> 1) & 1; m_ien = (d >> 2) & 1;
                   if ((d & 1) == 0) m_wd = 0; end
          1: begin m_cm = d & 3; m_ts = (d >> 2) & 3; end
          2: m_wd = d & 3;
          3: m_tk = d & 15;
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_en | (m_frc << 1) | (m_ien << 2);
      1: return m_cm | (m_ts << 2);
      2: return m_wd;
      3: return m_tk;
      4: return m_flag | (m_run << 1);
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  // every clock: both pins and the addressed register against the model
  always @(negedge clk) begin
    if (ir_out) hi_total++;
    if (go) begin
      check("R3 ir_out vs model", int'(ir_out), m_ir);
      check("R6 irq vs model", int'(irq), (m_flag != 0 && m_ien != 0) ? 1 : 0);
      check("R7 rdata vs model", int'(rdata), exp_rd(int'(addr)));
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #(Q); end
  endtask

  task automatic put(input int a, input int d);
    @(posedge clk); #(Q);
    wr_en = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(posedge clk); #(Q);
    wr_en = 1'b0;
  endtask

  task automatic peek(input int a, output int v);
    addr = 3'(a); rd_en = 1'b0;
    @(negedge clk);
    v = int'(rdata);
  endtask

  task automatic read_clear();
    @(posedge clk); #(Q);
    addr = 3'd4; rd_en = 1'b1;
    @(posedge clk); #(Q);
    rd_en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    int v, h0;
    int hi_tab[4];
    int per_tab[4];
    hi_tab[0] = 2; hi_tab[1] = 3; hi_tab[2] = 4; hi_tab[3] = 3;
    per_tab[0] = 8; per_tab[1] = 8; per_tab[2] = 12; per_tab[3] = 12;

    repeat (3) @(posedge clk);
    #(Q); rst_n = 1'b1; go = 1'b1;

    // R10 reset state
    for (int a = 0; a < 5; a++) begin
      peek(a, v); check("R10 register reset value", v, 0);
    end
    check("R10 ir_out after reset", int'(ir_out), 0);
    check("R10 irq after reset", int'(irq), 0);

    // R1 and R8: forced carrier for each shape
    for (int m = 0; m < 4; m++) begin
      put(1, m);
      put(0, 3);
      idle(20);
      h0 = hi_total;
      idle(4 * per_tab[m]);
      check("R1 high clocks in four carrier periods", hi_total - h0, 4 * hi_tab[m]);
      check("R8 forced carrier without burst", (hi_total - h0) > 0 ? 1 : 0, 1);
      put(0, 0);
      idle(400);
      peek(4, v); check("R7 stopped after tau boundary", (v >> 1) & 1, 0);
      check("R9 low while stopped", int'(ir_out), 0);
    end

    // R2: one-tau burst length follows the tau select
    put(1, 4);                   // shape 0, tau 16
    put(0, 1); put(2, 1);
    h0 = hi_total; idle(3 * 128 + 10);
    check("R2 one tau of 16 carrier periods", hi_total - h0, 32);
    put(0, 0); idle(400);
    put(1, 12);                  // shape 0, tau 32
    put(0, 1); put(2, 1);
    h0 = hi_total; idle(3 * 256 + 10);
    check("R2 one tau of 32 carrier periods", hi_total - h0, 64);
    put(0, 0); idle(400);

    // R3: three-tau burst, then no repeat without a new write
    put(1, 2);                   // shape 2 (12, 4 high), tau 12 -> 144 clocks
    put(0, 1); put(2, 3);
    h0 = hi_total; idle(5 * 144);
    check("R3 three tau burst length", hi_total - h0, 3 * 12 * 4);
    h0 = hi_total; idle(2 * 144);
    check("R3 no burst without a new write", hi_total - h0, 0);
    peek(2, v); check("R4 length still readable", v, 3);

    // R4 and R7: switching off clears the length, stop waits for tau
    put(0, 0);
    peek(2, v); check("R4 length cleared by off write", v, 0);
    peek(4, v); check("R7 still running before boundary", (v >> 1) & 1, 1);
    idle(200);
    peek(4, v); check("R7 stopped after boundary", (v >> 1) & 1, 0);

    // R4: running with zero length keeps the pin low
    put(0, 1);
    h0 = hi_total; idle(3 * 144);
    check("R4 zero length keeps pin low", hi_total - h0, 0);

    // R5 and R6: tau counter, masking, clear on read, restart
    put(3, 2);
    idle(2 * 144 + 20);
    peek(4, v); check("R5 flag after two boundaries", v & 1, 1);
    check("R6 irq masked", int'(irq), 0);
    read_clear();
    peek(4, v); check("R6 flag cleared by read", v & 1, 0);
    put(0, 5);
    put(3, 3);
    idle(2 * 144 - 10);
    put(3, 3);
    idle(2 * 144 - 10);
    peek(4, v); check("R5 rewrite restarts the count", v & 1, 0);
    peek(3, v); check("R5 count value held", v, 3);
    check("R6 no irq before completion", int'(irq), 0);
    idle(144 + 20);
    peek(4, v); check("R5 flag after third boundary", v & 1, 1);
    check("R6 irq with enable", int'(irq), 1);
    read_clear();
    check("R6 irq drops after read", int'(irq), 0);
    put(0, 0); idle(200);
    check("R9 low after final stop", int'(ir_out), 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule